// File: doc/BRIEF.md
# Flash Chip-Select Window Decoder

This block maps a slice of a system bus address space onto several serial flash devices. It keeps one segment register per chip select. Each register holds the lower and upper bound of that select's window, counted in 8 MB units. For every valid bus address, the block reports which select's window contains the address and the byte offset into that window. When no window claims the address, it raises a miss flag, which the bus side turns into an error response.

Software normally lays the windows out so that they tile one contiguous region. Select 0 opens the region, and each later window starts where the previous one ends. A window whose lower bound is not below its upper bound is closed. When windows overlap because of a misconfiguration, the decoder still grants exactly one select.

Top module: `flash_cs_window_dec`

## Requirements
- R1: After reset every segment register reads as zero, every window is closed, and any valid address reports a miss.
- R2: The segment register of select n sits at byte offset 0x30 + 4·n on the configuration port. A write lands on the clock edge where `cfg_wr` is high, and the readback shows it from the next cycle on. A write to any other offset changes no register. A read of any other offset returns zero.
- R3: Bits 31:24 of a segment register hold the upper bound and bits 23:16 hold the lower bound. Readback returns the stored bounds in those positions, with bits 15:0 always zero.
- R4: Each bound stands for a byte address equal to its value shifted left by 23. An address falls in a window when lower ≤ address < upper, so the upper bound is exclusive.
- R5: A window whose lower bound is greater than or equal to its upper bound never matches any address.
- R6: When several open windows contain the address, only the lowest-numbered select is asserted on `cs_hit`. At most one bit of `cs_hit` is ever high.
- R7: While `bus_valid` is high, exactly one of these holds: `miss` is high, or one bit of `cs_hit` is high. While `bus_valid` is low, both `miss` and `cs_hit` are zero.
- R8: `win_offset` equals the address minus the byte lower bound of the granted window. It is zero when nothing is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the segment registers |
| cfg_addr | input | CFG_AW | Byte offset on the configuration port |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Readback of the register at `cfg_addr` |
| bus_valid | input | 1 | Bus address is valid |
| bus_addr | input | ADDR_W | Bus byte address to decode |
| cs_hit | output | NUM_CS | One-hot granted chip select |
| miss | output | 1 | Valid address matched no open window |
| win_offset | output | ADDR_W | Offset of the address inside the granted window |

## Verification
Three windows are programmed: two that tile back to back, and a third that overlaps the second and runs past it. Addresses are then walked through this layout. Addresses just below and at each lower bound, and one below and at each upper bound, separate an inclusive upper bound from an exclusive one. Addresses inside the overlap show whether the lowest select wins. Offsets taken deep inside windows expose a wrong base being subtracted. The third window is then rewritten as an empty window and as an inverted one, to show that a closed window drops out while the others keep decoding. Writes to unused offsets, a write with nonzero low data bits, and decoding with the strobe low cover the configuration port and the idle outputs.

// File: rtl/flash_win_pkg.sv
package flash_win_pkg;

  localparam int unsigned SEG_FIELD_W = 8;
  localparam int unsigned SEG_WORD_W  = 32;
  localparam int unsigned SEG_PAD_W   = SEG_WORD_W - 2 * SEG_FIELD_W;

  // upper bound in the high byte, lower bound below it
  typedef struct packed {
    logic [SEG_FIELD_W-1:0] lim;
    logic [SEG_FIELD_W-1:0] base;
  } seg_t;

  function automatic seg_t word_to_seg(input logic [SEG_WORD_W-1:0] w);
    seg_t s;
    s.lim  = w[SEG_WORD_W-1 -: SEG_FIELD_W];
    s.base = w[SEG_WORD_W-1-SEG_FIELD_W -: SEG_FIELD_W];
    return s;
  endfunction

  function automatic logic [SEG_WORD_W-1:0] seg_to_word(input seg_t s);
    return {s.lim, s.base, {SEG_PAD_W{1'b0}}};
  endfunction

  function automatic logic seg_is_open(input seg_t s);
    return s.base < s.lim;
  endfunction

endpackage

// File: rtl/fcw_seg_regs.sv
module fcw_seg_regs
  import flash_win_pkg::*;
#(
  parameter int unsigned NUM_CS   = 3,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned REG_BASE = 'h30
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [SEG_WORD_W-1:0]       cfg_wdata,
  output logic [SEG_WORD_W-1:0]       cfg_rdata,
  output seg_t [NUM_CS-1:0]           seg_q
);

  localparam int unsigned STRIDE = 4;

  logic [NUM_CS-1:0] reg_sel;
  logic              unused_lo;

  assign unused_lo = ^cfg_wdata[SEG_PAD_W-1:0];

  for (genvar n = 0; n < NUM_CS; n++) begin : g_reg
    assign reg_sel[n] = (cfg_addr == CFG_AW'(REG_BASE + STRIDE * n));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seg_q[n] <= '0;
      end else if (cfg_wr && reg_sel[n]) begin
        seg_q[n] <= word_to_seg(cfg_wdata);
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int n = 0; n < NUM_CS; n++) begin
      if (reg_sel[n]) cfg_rdata |= seg_to_word(seg_q[n]);
    end
  end

endmodule

// File: rtl/fcw_win_cmp.sv
module fcw_win_cmp
  import flash_win_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned UNIT_SHIFT = 23
) (
  input  seg_t              seg,
  input  logic [ADDR_W-1:0] addr,
  output logic              open,
  output logic              hit,
  output logic [ADDR_W-1:0] lo_byte
);

  logic [ADDR_W-1:0] hi_byte;

  assign lo_byte = ADDR_W'(seg.base) << UNIT_SHIFT;
  assign hi_byte = ADDR_W'(seg.lim) << UNIT_SHIFT;
  assign open    = seg_is_open(seg);
  assign hit     = open && (addr >= lo_byte) && (addr < hi_byte);

endmodule

// File: rtl/fcw_prio_sel.sv
module fcw_prio_sel #(
  parameter int unsigned NUM_CS = 3,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                           valid,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_CS-1:0]              win_hit,
  input  logic [NUM_CS-1:0][ADDR_W-1:0]  win_lo,
  output logic [NUM_CS-1:0]              grant,
  output logic                           miss,
  output logic [ADDR_W-1:0]              offset
);

  logic [NUM_CS-1:0] cand;
  logic [ADDR_W-1:0] sel_lo;

  assign cand  = valid ? win_hit : '0;
  assign grant = cand & (~cand + NUM_CS'(1));
  assign miss  = valid && (cand == '0);

  always_comb begin
    sel_lo = '0;
    for (int n = 0; n < NUM_CS; n++) begin
      if (grant[n]) sel_lo |= win_lo[n];
    end
  end

  assign offset = (grant != '0) ? (addr - sel_lo) : '0;

endmodule

// File: rtl/flash_cs_window_dec.sv
module flash_cs_window_dec
  import flash_win_pkg::*;
#(
  parameter int unsigned NUM_CS     = 3,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CFG_AW     = 8,
  parameter int unsigned REG_BASE   = 'h30,
  parameter int unsigned UNIT_SHIFT = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  input  logic                  bus_valid,
  input  logic [ADDR_W-1:0]     bus_addr,
  output logic [NUM_CS-1:0]     cs_hit,
  output logic                  miss,
  output logic [ADDR_W-1:0]     win_offset
);

  seg_t [NUM_CS-1:0]             seg_q;
  logic [NUM_CS-1:0]             win_open;
  logic [NUM_CS-1:0]             win_hit;
  logic [NUM_CS-1:0][ADDR_W-1:0] win_lo;

  fcw_seg_regs #(
    .NUM_CS   (NUM_CS),
    .CFG_AW   (CFG_AW),
    .REG_BASE (REG_BASE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .seg_q     (seg_q)
  );

  for (genvar n = 0; n < NUM_CS; n++) begin : g_win
    fcw_win_cmp #(
      .ADDR_W     (ADDR_W),
      .UNIT_SHIFT (UNIT_SHIFT)
    ) u_cmp (
      .seg     (seg_q[n]),
      .addr    (bus_addr),
      .open    (win_open[n]),
      .hit     (win_hit[n]),
      .lo_byte (win_lo[n])
    );
  end

  fcw_prio_sel #(
    .NUM_CS (NUM_CS),
    .ADDR_W (ADDR_W)
  ) u_sel (
    .valid   (bus_valid),
    .addr    (bus_addr),
    .win_hit (win_hit),
    .win_lo  (win_lo),
    .grant   (cs_hit),
    .miss    (miss),
    .offset  (win_offset)
  );

endmodule

// File: rtl/flash_cs_window_dec_chk.sv
module flash_cs_window_dec_chk #(
  parameter int unsigned NUM_CS   = 3,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned REG_BASE = 'h30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              bus_valid,
  input logic [NUM_CS-1:0] cs_hit,
  input logic              miss,
  input logic [ADDR_W-1:0] win_offset,
  input logic [NUM_CS-1:0] win_open,
  input logic [NUM_CS-1:0] win_hit
);

  // R3
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15:0] == 16'h0);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_wr) && $past(cfg_addr) == CFG_AW'(REG_BASE)
     && cfg_addr == CFG_AW'(REG_BASE))
    |-> cfg_rdata == {$past(cfg_wdata[31:16]), 16'h0});

  // R5
  closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hit & ~win_open) == '0);

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_hit));

  // R6
  grant_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hit & ~win_hit) == '0);

  // R7
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> cs_hit == '0);

  // R7
  valid_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (miss || cs_hit != '0));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (!miss && cs_hit == '0));

  // R8
  miss_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hit == '0) |-> win_offset == '0);

endmodule

bind flash_cs_window_dec flash_cs_window_dec_chk #(
  .NUM_CS   (NUM_CS),
  .ADDR_W   (ADDR_W),
  .CFG_AW   (CFG_AW),
  .REG_BASE (REG_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .bus_valid  (bus_valid),
  .cs_hit     (cs_hit),
  .miss       (miss),
  .win_offset (win_offset),
  .win_open   (win_open),
  .win_hit    (win_hit)
);

// File: tb/flash_cs_window_dec_test.sv
module flash_cs_window_dec_test;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NCS = 3;
  localparam int unsigned NV  = 9;

  // addr, expected grant, expected miss, expected offset
  // windows: cs0 [0x01000000,0x02000000) cs1 [0x02000000,0x03000000)
  //          cs2 [0x02800000,0x04800000)
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h00FF_FFFF, 32'h0100_0000, 32'h01FF_FFFF, 32'h0200_0000, 32'h0280_0010,
    32'h0300_0000, 32'h047F_FFFF, 32'h0480_0000, 32'hFFFF_FFFF};
  localparam logic [2:0] V_HIT [NV] = '{
    3'b000, 3'b001, 3'b001, 3'b010, 3'b010, 3'b100, 3'b100, 3'b000, 3'b000};
  localparam logic V_MISS [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] V_OFF [NV] = '{
    32'h0, 32'h0, 32'h00FF_FFFF, 32'h0, 32'h0080_0010,
    32'h0080_0000, 32'h01FF_FFFF, 32'h0, 32'h0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [NCS-1:0] cs_hit;
  logic        miss;
  logic [31:0] win_offset;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cs_window_dec #(.NUM_CS(NCS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .cs_hit(cs_hit), .miss(miss), .win_offset(win_offset)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] off, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = off;
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic [2:0] eh,
                      input logic em, input logic [31:0] eo);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a;
    #1;
    chk({tag, " hit"}, 32'(cs_hit), 32'(eh));
    chk({tag, " miss"}, 32'(miss), 32'(em));
    chk({tag, " off"}, win_offset, eo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd("R1 rb cs0", 8'h30, 32'h0);
    rd("R1 rb cs2", 8'h38, 32'h0);
    look("R1 decode", 32'h0100_0000, 3'b000, 1'b1, 32'h0);
    @(negedge clk); rst_n = 1'b1; bus_valid = 1'b0;

    // R2 write lands on the next cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h30; cfg_wdata = 32'h0402_0000;
    #1 chk("R2 before edge", cfg_rdata, 32'h0);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1 chk("R2 after edge", cfg_rdata, 32'h0402_0000);

    // R3 low bits dropped on readback
    wr(8'h34, 32'h0604_ABCD);
    rd("R3 low bits", 8'h34, 32'h0604_0000);
    wr(8'h38, 32'h0905_0000);
    rd("R3 cs2", 8'h38, 32'h0905_0000);

    // R2 stray offsets
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h31, 32'hFFFF_FFFF);
    rd("R2 cs0 kept", 8'h30, 32'h0402_0000);
    rd("R2 cs1 kept", 8'h34, 32'h0604_0000);
    rd("R2 cs2 kept", 8'h38, 32'h0905_0000);
    rd("R2 unused rd", 8'h3C, 32'h0);

    // R4 R6 R8 table walk
    for (int i = 0; i < NV; i++) begin
      look($sformatf("R4 R6 R8 vec%0d", i), V_ADDR[i], V_HIT[i], V_MISS[i], V_OFF[i]);
    end

    // R7 idle
    @(negedge clk); bus_valid = 1'b0; bus_addr = 32'h0100_0000;
    #1 chk("R7 idle hit", 32'(cs_hit), 32'h0);
    chk("R7 idle miss", 32'(miss), 32'h0);

    // R5 empty then inverted window on cs2
    wr(8'h38, 32'h0909_0000);
    look("R5 empty", 32'h0300_0000, 3'b000, 1'b1, 32'h0);
    look("R5 others", 32'h0280_0000, 3'b010, 1'b0, 32'h0080_0000);
    wr(8'h38, 32'h0609_0000);
    look("R5 inverted", 32'h0300_0000, 3'b000, 1'b1, 32'h0);
    look("R5 inverted mid", 32'h0400_0000, 3'b000, 1'b1, 32'h0);

    @(negedge clk); bus_valid = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule